// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers up to 32 one-cycle event pulses from neighbouring logic into a sticky status word. A register port reads that word, and the read clears every stored bit it returned. One bit position is reserved as a pass-through for an interrupt level coming from a management sub-unit. That bit is never stored here. It shows the live level, a status read does not clear it, and the mask cannot block it.

A mask word with one bit per status bit decides which stored events may raise the single interrupt output. A mask bit of 1 blocks its event. Two summary flags report whether any event in the fatal-error group, or any event in the non-fatal group, is pending. The flags ignore the mask.

Software uses the unit in three steps. It programs the mask, waits for the interrupt, and then reads the status word once. That single read both reports the causes and acknowledges them.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the stored status is all zeros, the mask reads 0xFF7FFFFF and `irq_o` is low.
- R2: A pulse on `evt_i[k]` (k other than 23) sets stored status bit k at the next clock edge. The bit stays set until a status read.
- R3: When `reg_rd_i` is high and `reg_sel_i` is 0 (status), `reg_rdata_o` returns the status in that same cycle, and every stored bit clears at the clock edge. An event in the same cycle as the read is not lost: its bit is set after the edge.
- R4: Bit 23 of the status read data always equals `sub_lvl_i`. A status read leaves it unaffected, and a pulse on `evt_i[23]` has no effect.
- R5: A write with `reg_wr_i` high and `reg_sel_i` 1 (mask) loads `reg_wdata_i` into the mask at the clock edge. With `reg_sel_i` 1, `reg_rdata_o` returns the mask.
- R6: `irq_o` is registered. In each cycle it equals the OR over the stored status bits whose mask bit is 0, as they stood in the previous cycle, together with the previous cycle's `sub_lvl_i`.
- R7: Mask bit 23 has no effect. `sub_lvl_i` high raises `irq_o` one cycle later even when the mask is all ones.
- R8: `fatal_o` is high exactly when a stored status bit within 0xFC7C0000 is set. `nonfatal_o` is high exactly when a stored bit within 0x0002FEFC is set. Neither flag depends on the mask.
- R9: A write with `reg_sel_i` 0 changes neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | One-cycle event pulses, one per status bit |
| sub_lvl_i | input | 1 | Interrupt level from the management sub-unit (status bit 23) |
| reg_rd_i | input | 1 | Read strobe; with select 0 it clears the status |
| reg_wr_i | input | 1 | Write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt output |
| fatal_o | output | 1 | Any fatal-group event pending |
| nonfatal_o | output | 1 | Any non-fatal-group event pending |

## Verification
The properties assume that every input holds a known value from the first clock edge after reset is released. The event-versus-read property also treats any event present during a status read as the only thing left stored afterwards, so events must be genuine one-cycle pulses and not held levels. The bench meets both assumptions: it drives every input on the falling edge from time zero, keeps `sub_lvl_i` and all strobes low during reset, and raises each event for exactly one cycle. Read and write strobes are also placed on the falling edge, so the clearing read and the mask load always land on the next rising edge.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int          STAT_W       = 32;
    localparam int          PASS_IDX     = 23;
    localparam logic [31:0] MASK_RESET   = 32'hFF7F_FFFF;
    localparam logic [31:0] FATAL_SET    = 32'hFC7C_0000;
    localparam logic [31:0] NONFATAL_SET = 32'h0002_FEFC;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_stat_bank.sv
// Sticky event store with clear-on-read; the pass-through position is never stored.
module irq_stat_bank #(
    parameter int W        = 32,
    parameter int PASS_BIT = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);
    localparam logic [W-1:0] PASS_M = W'(1) << PASS_BIT;

    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.bits = '0;
        end
        // new events always win over the clear so none is lost
        st_d.bits = (st_d.bits | evt_i) & ~PASS_M;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.bits;
endmodule

// File: rtl/irq_mask_reg.sv
// Mask word, one bit per status bit; 1 blocks the event.
module irq_mask_reg #(
    parameter int           W        = 32,
    parameter logic [W-1:0] RST_VAL  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (ld_i) begin
            mk_d.bits = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk_q.bits <= RST_VAL;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign mask_o = mk_q.bits;
endmodule

// File: rtl/irq_combine.sv
// Per-bit gating, registered interrupt and group summary flags.
module irq_combine #(
    parameter int           W         = 32,
    parameter int           PASS_BIT  = 23,
    parameter logic [W-1:0] FATAL_M   = '0,
    parameter logic [W-1:0] NONFATAL_M = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    input  logic         sub_lvl_i,
    output logic         irq_o,
    output logic         fatal_o,
    output logic         nonfatal_o
);
    typedef struct packed {
        logic irq;
    } comb_t;

    comb_t        cb_d, cb_q;
    logic [W-1:0] live;

    for (genvar i = 0; i < W; i++) begin : g_live
        if (i == PASS_BIT) begin : g_pass
            // the mask position of the pass-through bit is ignored
            assign live[i] = sub_lvl_i;
        end else begin : g_gate
            assign live[i] = stat_i[i] & ~mask_i[i];
        end
    end

    always_comb begin
        cb_d     = cb_q;
        cb_d.irq = |live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cb_q <= '0;
        end else begin
            cb_q <= cb_d;
        end
    end

    assign irq_o      = cb_q.irq;
    assign fatal_o    = |(stat_i & FATAL_M);
    assign nonfatal_o = |(stat_i & NONFATAL_M);
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
    import irq_stat_pkg::*;
#(
    parameter int           W          = STAT_W,
    parameter int           PASS_BIT   = PASS_IDX,
    parameter logic [W-1:0] MASK_RST   = MASK_RESET,
    parameter logic [W-1:0] FATAL_GRP  = FATAL_SET,
    parameter logic [W-1:0] NONFAT_GRP = NONFATAL_SET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         sub_lvl_i,
    input  logic         reg_rd_i,
    input  logic         reg_wr_i,
    input  logic         reg_sel_i,
    input  logic [W-1:0] reg_wdata_i,
    output logic [W-1:0] reg_rdata_o,
    output logic         irq_o,
    output logic         fatal_o,
    output logic         nonfatal_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] stat_view;
    logic         stat_rd;
    logic         mask_wr;

    assign stat_rd = reg_rd_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
    assign mask_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);

    irq_stat_bank #(.W(W), .PASS_BIT(PASS_BIT)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (stat_rd),
        .stat_o (stat_q)
    );

    irq_mask_reg #(.W(W), .RST_VAL(MASK_RST)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (mask_wr),
        .val_i  (reg_wdata_i),
        .mask_o (mask_q)
    );

    irq_combine #(
        .W(W), .PASS_BIT(PASS_BIT), .FATAL_M(FATAL_GRP), .NONFATAL_M(NONFAT_GRP)
    ) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (stat_q),
        .mask_i     (mask_q),
        .sub_lvl_i  (sub_lvl_i),
        .irq_o      (irq_o),
        .fatal_o    (fatal_o),
        .nonfatal_o (nonfatal_o)
    );

    always_comb begin
        stat_view           = stat_q;
        stat_view[PASS_BIT] = sub_lvl_i;
    end

    assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_MASK) ? mask_q : stat_view;
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
    parameter int           W         = 32,
    parameter int           PASS_BIT  = 23,
    parameter logic [W-1:0] FATAL_GRP = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_i,
    input logic         sub_lvl_i,
    input logic         reg_rd_i,
    input logic         reg_wr_i,
    input logic         reg_sel_i,
    input logic [W-1:0] reg_wdata_i,
    input logic         irq_o,
    input logic         fatal_o,
    input logic [W-1:0] stat_q,
    input logic [W-1:0] mask_q
);
    localparam logic [W-1:0] PASS_M = W'(1) << PASS_BIT;

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & ~PASS_M)) |=>
            ((stat_q & $past(evt_i & ~PASS_M)) == $past(evt_i & ~PASS_M)));

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !reg_sel_i) |=> (stat_q == ($past(evt_i) & ~PASS_M)));

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_sel_i) |=> (mask_q == $past(reg_wdata_i)));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == ((|$past(stat_q & ~mask_q & ~PASS_M)) || $past(sub_lvl_i))));

    p_lvl_unmaskable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sub_lvl_i |=> irq_o);

    p_fatal_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & FATAL_GRP)) |=> fatal_o);

    p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_sel_i) |=> $stable(mask_q));
endmodule

bind irq_stat_unit irq_stat_chk #(
    .W(W), .PASS_BIT(PASS_BIT), .FATAL_GRP(FATAL_GRP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .sub_lvl_i   (sub_lvl_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .fatal_o     (fatal_o),
    .stat_q      (stat_q),
    .mask_q      (mask_q)
);

// File: tb/irq_stat_unit_test.sv
`timescale 1ns/1ps
module irq_stat_unit_test;
    localparam logic [31:0] RST_MASK = 32'hFF7F_FFFF;
    localparam logic [31:0] FAT      = 32'hFC7C_0000;
    localparam logic [31:0] NFAT     = 32'h0002_FEFC;
    localparam logic [31:0] B23      = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        lvl = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fatal, nonfatal;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_stat_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sub_lvl_i(lvl),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .fatal_o(fatal), .nonfatal_o(nonfatal)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference, updated on every rising edge
    logic [31:0] m_stat = '0;
    logic [31:0] m_mask = RST_MASK;
    logic        m_irq  = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0;
            m_mask = RST_MASK;
            m_irq  = 1'b0;
        end else begin
            m_irq = ((m_stat & ~m_mask & ~B23) != 0) || lvl;
            if (rd && !sel) m_stat = '0;
            m_stat = (m_stat | evt) & ~B23;
            if (wr && sel) m_mask = wdata;
        end
    end

    always @(negedge clk) begin
        #1;
        if (!done) begin
            check(sel ? "R5 mask read" : "R2 status read", rdata,
                  sel ? m_mask : (m_stat | (lvl ? B23 : 32'h0)));
            check("R6 irq", {31'h0, irq}, {31'h0, m_irq});
            check("R8 fatal", {31'h0, fatal}, {31'h0, ((m_stat & FAT) != 0)});
            check("R8 nonfatal", {31'h0, nonfatal}, {31'h0, ((m_stat & NFAT) != 0)});
        end
    end

    task automatic drive(input logic [31:0] e, input logic r, input logic w,
                         input logic s, input logic [31:0] d);
        @(negedge clk);
        evt = e; rd = r; wr = w; sel = s; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1 check("R1 status after reset", rdata, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        drive('0, 1'b0, 1'b0, 1'b1, '0);
        #1 check("R1 mask after reset", rdata, RST_MASK);
        @(negedge clk) rst_n = 1'b1;
        idle(1);

        // R2: events stick; reset mask blocks them
        drive(32'h0000_0101, 1'b0, 1'b0, 1'b0, '0);
        idle(3);
        #1 check("R2 sticky bits", rdata, 32'h0000_0101);
        check("R2 masked no irq", {31'h0, irq}, 32'h0);

        // R3: read returns then clears
        drive('0, 1'b1, 1'b0, 1'b0, '0);
        #1 check("R3 read value", rdata, 32'h0000_0101);
        idle(1);
        #1 check("R3 cleared", rdata, 32'h0);
        drive(32'h0000_0010, 1'b0, 1'b0, 1'b0, '0);
        drive(32'h0000_0004, 1'b1, 1'b0, 1'b0, '0);
        #1 check("R3 read with event", rdata, 32'h0000_0010);
        idle(1);
        #1 check("R3 same-cycle event kept", rdata, 32'h0000_0004);
        drive('0, 1'b1, 1'b0, 1'b0, '0);
        idle(1);

        // R4: pass-through bit
        drive(B23, 1'b0, 1'b0, 1'b0, '0);
        idle(1);
        #1 check("R4 event 23 ignored", rdata, 32'h0);
        lvl = 1'b1;
        #1 check("R4 level mirrored", rdata, B23);
        drive('0, 1'b1, 1'b0, 1'b0, '0);
        idle(1);
        #1 check("R4 not cleared by read", rdata, B23);
        // R7: full mask still lets the level through
        check("R7 level raises irq", {31'h0, irq}, 32'h1);
        lvl = 1'b0;
        idle(2);
        #1 check("R7 irq drops with level", {31'h0, irq}, 32'h0);

        // R5: mask write and read back
        drive('0, 1'b0, 1'b1, 1'b1, 32'h1234_5678);
        drive('0, 1'b0, 1'b0, 1'b1, '0);
        #1 check("R5 mask readback", rdata, 32'h1234_5678);

        // R6: gating by mask
        drive('0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFE);
        drive(32'h0000_0002, 1'b0, 1'b0, 1'b0, '0);
        idle(2);
        #1 check("R6 masked bit no irq", {31'h0, irq}, 32'h0);
        drive(32'h0000_0001, 1'b0, 1'b0, 1'b0, '0);
        idle(1);
        #1 check("R6 irq not yet (registered)", {31'h0, irq}, 32'h0);
        idle(1);
        #1 check("R6 unmasked bit irq", {31'h0, irq}, 32'h1);
        drive('0, 1'b1, 1'b0, 1'b0, '0);
        idle(2);
        #1 check("R6 irq after clear", {31'h0, irq}, 32'h0);

        // R8: group flags
        drive(32'h8000_0000, 1'b0, 1'b0, 1'b0, '0);
        idle(1);
        #1 check("R8 fatal set", {31'h0, fatal}, 32'h1);
        check("R8 nonfatal clear", {31'h0, nonfatal}, 32'h0);
        drive(32'h0000_0004, 1'b1, 1'b0, 1'b0, '0);
        idle(1);
        #1 check("R8 nonfatal set", {31'h0, nonfatal}, 32'h1);
        check("R8 fatal cleared", {31'h0, fatal}, 32'h0);
        drive(32'h0001_0000, 1'b1, 1'b0, 1'b0, '0);
        idle(1);
        #1 check("R8 normal event neither", {30'h0, fatal, nonfatal}, 32'h0);

        // R9: write to status select ignored
        drive('0, 1'b1, 1'b0, 1'b0, '0);
        drive('0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        idle(1);
        #1 check("R9 status unchanged", rdata, 32'h0);
        drive('0, 1'b0, 1'b0, 1'b1, '0);
        #1 check("R9 mask unchanged", rdata, 32'hFFFF_FFFE);

        // mixed traffic against the reference model
        for (int k = 0; k < 600; k++) begin
            logic [31:0] e;
            e = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            if ($urandom % 25 == 0) lvl = ~lvl;
            drive(e, ($urandom % 6 == 0), ($urandom % 12 == 0),
                  $urandom % 2, $urandom);
        end
        idle(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule